// File: doc/BRIEF.md
# Table-Driven Sequencer

This block is a small control sequencer whose entire transition logic lives in one synchronous read-only lookup table. Each table address joins the present state code with the six condition inputs. The word read out holds the next state code together with a set of decoded status flags. The register that captures the read data is the state itself. Its state field is wired straight back into the upper address bits, so the machine advances one transition per clock with no separate next-state logic.

The table is filled when the design is elaborated. A function that describes the transitions computes every entry, so the array maps onto a single block memory of 512 words. The sequence is as follows. Idle waits for a start condition. It then passes through a setup phase and a decision phase. From the decision phase it takes one of two paths to a commit phase, and it ends in a single-cycle done phase. An abort condition returns the machine to idle from any working phase.

Top module: `table_fsm`

## Requirements
- R1: When `rst` is high at a rising edge, the state after that edge is code 0 (idle) and the flags read 4'b0001, whatever the conditions are.
- R2: State code 7 is never entered. Every table entry for code 7 holds next state 0, so the machine can always leave that code.
- R3: From idle (0), the machine moves to setup (1) when condition bit 0 is set, and otherwise stays in idle.
- R4: In codes 1 to 5, condition bit 5 (abort) sends the machine to idle on the next edge. Abort wins over every other condition bit.
- R5: From setup (1), condition bit 1 moves the machine to decide (2), and otherwise it holds. In decide, bit 2 selects path A (3) before bit 3 selects path B (4). With neither bit set, it holds.
- R6: From path A (3) or path B (4), condition bit 4 moves the machine to commit (5), and otherwise it holds.
- R7: From commit (5), condition bit 1 moves the machine to done (6), and otherwise it holds. Done always goes to idle on the next edge.
- R8: The flags always describe the state shown in the same cycle, with no extra latency. Bit 0 means idle, bit 1 means working (codes 1 to 5), bit 2 means done, and bit 3 means path B. Exactly one of bits 0 to 2 is set.
- R9: A condition value present at a rising edge decides the state shown right after that edge: one cycle of latency, with no output pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | 6 | Condition inputs, sampled every edge |
| state_o | output | 3 | Encoded current state |
| flags_o | output | 4 | Decoded state flags stored in the table word |

## Verification
The bench aims at priority collisions. It raises abort together with every advance bit, and it sets both branch bits while in decide. A table that gets either ordering wrong lands in the wrong state one cycle later. It also pulses a start condition for a single cycle and checks the very next state. An extra output register would show the old state there, and the flags would trail the state by one cycle. Several reset assertions in the middle of a run show whether reset truly overrides the stored word and does not just load a table entry. Random traffic with abort held rare drives the machine through both branch paths and into done many times. A wrong done-to-idle entry, or any step into code 7, therefore shows up against the bench model.

// File: rtl/table_fsm.sv
module table_fsm #(
  parameter int SW = 3,
  parameter int CW = 6,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cond_i,
  output logic [SW-1:0] state_o,
  output logic [FW-1:0] flags_o
);
  localparam int AW    = SW + CW;
  localparam int DEPTH = 1 << AW;
  localparam int DW    = SW + FW;

  localparam logic [SW-1:0] ST_IDLE   = SW'(0);
  localparam logic [SW-1:0] ST_SETUP  = SW'(1);
  localparam logic [SW-1:0] ST_DECIDE = SW'(2);
  localparam logic [SW-1:0] ST_PATHA  = SW'(3);
  localparam logic [SW-1:0] ST_PATHB  = SW'(4);
  localparam logic [SW-1:0] ST_COMMIT = SW'(5);
  localparam logic [SW-1:0] ST_DONE   = SW'(6);

  function automatic logic [SW-1:0] spec_next(logic [SW-1:0] s, logic [CW-1:0] c);
    logic [SW-1:0] n;
    n = ST_IDLE;
    case (s)
      ST_IDLE:   n = c[0] ? ST_SETUP : ST_IDLE;
      ST_SETUP:  n = c[5] ? ST_IDLE : (c[1] ? ST_DECIDE : ST_SETUP);
      ST_DECIDE: n = c[5] ? ST_IDLE : (c[2] ? ST_PATHA : (c[3] ? ST_PATHB : ST_DECIDE));
      ST_PATHA:  n = c[5] ? ST_IDLE : (c[4] ? ST_COMMIT : ST_PATHA);
      ST_PATHB:  n = c[5] ? ST_IDLE : (c[4] ? ST_COMMIT : ST_PATHB);
      ST_COMMIT: n = c[5] ? ST_IDLE : (c[1] ? ST_DONE : ST_COMMIT);
      default:   n = ST_IDLE;
    endcase
    return n;
  endfunction

  function automatic logic [FW-1:0] spec_flags(logic [SW-1:0] s);
    logic [FW-1:0] f;
    f = '0;
    f[0] = (s == ST_IDLE);
    f[1] = (s >= ST_SETUP) && (s <= ST_COMMIT);
    f[2] = (s == ST_DONE);
    f[3] = (s == ST_PATHB);
    return f;
  endfunction

  function automatic logic [DW-1:0] entry(int a);
    logic [AW-1:0]  av;
    logic [SW-1:0]  nx;
    av = AW'(a);
    nx = spec_next(av[AW-1:CW], av[CW-1:0]);
    return {spec_flags(nx), nx};
  endfunction

  localparam logic [DW-1:0] RESET_WORD = {spec_flags(ST_IDLE), ST_IDLE};

  logic [DW-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = entry(g);
  end

  logic [DW-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) word_q <= RESET_WORD;
    else     word_q <= rom[{word_q[SW-1:0], cond_i}];
  end

  assign state_o = word_q[SW-1:0];
  assign flags_o = word_q[DW-1:SW];

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (state_o == ST_IDLE));

  p_no_code7_r2: assert property (@(posedge clk) disable iff (rst)
    state_o != SW'(7));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_IDLE && !cond_i[0]) |=> (state_o == ST_IDLE));

  p_abort_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (state_o >= ST_SETUP && state_o <= ST_COMMIT && cond_i[5]) |=> (state_o == ST_IDLE));

  p_done_exit_r7: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_DONE) |=> (state_o == ST_IDLE));

  p_flag_class_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(flags_o[2:0]) == 1);
endmodule

// File: tb/table_fsm_test.sv
module table_fsm_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] cond = '0;
  logic [2:0] state_o;
  logic [3:0] flags_o;
  int checks = 0;
  int fails  = 0;
  logic [2:0] exp_s = 3'd0;

  table_fsm uut (.clk(clk), .rst(rst), .cond_i(cond), .state_o(state_o), .flags_o(flags_o));

  always #10 clk = ~clk;

  function automatic logic [2:0] ref_next(logic [2:0] s, logic [5:0] c);
    case (s)
      3'd0: return c[0] ? 3'd1 : 3'd0;
      3'd1: return c[5] ? 3'd0 : (c[1] ? 3'd2 : 3'd1);
      3'd2: if (c[5]) return 3'd0; else if (c[2]) return 3'd3;
            else if (c[3]) return 3'd4; else return 3'd2;
      3'd3: return c[5] ? 3'd0 : (c[4] ? 3'd5 : 3'd3);
      3'd4: return c[5] ? 3'd0 : (c[4] ? 3'd5 : 3'd4);
      3'd5: return c[5] ? 3'd0 : (c[1] ? 3'd6 : 3'd5);
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [3:0] ref_flags(logic [2:0] s);
    return {s == 3'd4, s == 3'd6, (s >= 3'd1 && s <= 3'd5), s == 3'd0};
  endfunction

  function automatic string tag_of(logic r, logic [2:0] s, logic [5:0] c);
    if (r) return "R1";
    if (s == 3'd0) return "R3";
    if (c[5] && s <= 3'd5) return "R4";
    if (s <= 3'd2) return "R5";
    if (s <= 3'd4) return "R6";
    return "R7";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic r, logic [5:0] c, string tag);
    rst  = r;
    cond = c;
    exp_s = r ? 3'd0 : ref_next(exp_s, c);
    @(negedge clk);
    check(tag, state_o, exp_s);
    check("R8", flags_o, ref_flags(exp_s));
    checks++;
    if (state_o == 3'd7) begin
      fails++;
      $display("FAIL R2 actual=7 expected=not 7 t=%0t", $time);
    end
  endtask

  initial begin
    void'($urandom(32'd24681));
    @(negedge clk);
    step(1'b1, 6'h3f, "R1");
    step(1'b0, 6'b000000, "R3");
    step(1'b0, 6'b000001, "R9");
    step(1'b0, 6'b000000, "R5");
    step(1'b0, 6'b000010, "R5");
    step(1'b0, 6'b001100, "R5");
    step(1'b0, 6'b000000, "R6");
    step(1'b0, 6'b010000, "R6");
    step(1'b0, 6'b100010, "R4");
    step(1'b0, 6'b000001, "R3");
    step(1'b0, 6'b000010, "R5");
    step(1'b0, 6'b001000, "R5");
    step(1'b0, 6'b010000, "R6");
    step(1'b0, 6'b000010, "R7");
    step(1'b0, 6'b111111, "R7");
    step(1'b0, 6'b000001, "R3");
    step(1'b1, 6'b000010, "R1");
    step(1'b0, 6'b000001, "R3");
    step(1'b0, 6'b111111, "R4");
    for (int i = 0; i < 3000; i++) begin
      logic       r;
      logic [5:0] c;
      r = ($urandom % 97) == 0;
      c = 6'($urandom);
      if (($urandom % 8) != 0) c[5] = 1'b0;
      step(r, c, tag_of(r, exp_s, c));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule